// File: doc/BRIEF.md
# UART Interrupt Status and FIFO Level Trigger Logic

This block turns the state of a UART's 16-entry transmit and receive FIFOs, its receive error events and its clear-to-send change events into an 11-bit raw interrupt status vector, a masked status vector and one combined interrupt line. The FIFOs and the serial shift engines sit outside. They report their fill counts, a pulse for each received character, the four receive error pulses and a CTS change pulse. A bit-period tick drives the receive timeout.

The receive and transmit level triggers are chosen in eighths of the FIFO depth through a 6-bit level select register held inside the block. With the FIFOs disabled, the level triggers treat the FIFOs as single holding locations. Software clears raw bits by writing ones through a clear strobe. The mask register comes in as a plain input.

Status bit positions: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit level, 4 receive level, 1 CTS change. Bits 0, 3 and 2 always read 0.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The level code maps to a threshold in entries of the 16-deep FIFO: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14. The reserved codes 5, 6 and 7 behave as code 4.
- R2: With FIFOs enabled, receive bit 4 sets one clock after the receive fill becomes at or above its threshold. Transmit bit 5 sets one clock after the transmit fill becomes at or below its threshold. Each bit drops one clock after its condition goes false. A bit cleared by software stays clear until its condition goes false and then true again.
- R3: The level select register resets to code 2 for both directions (threshold 8). A write with `lvl_we_i` loads the receive code from `lvl_wdata_i[5:3]` and the transmit code from `lvl_wdata_i[2:0]`, and takes effect one clock later.
- R4: With `fifo_en_i` low, the receive condition is a fill other than 0 and the transmit condition is a fill of 0, whatever the level codes.
- R5: While the receive fill is not 0, the counter counts `bit_tick_i` pulses. A `rx_push_i` pulse or an empty FIFO sets the counter to 0. Bit 6 sets one clock after the 32nd tick. Bit 6 drops one clock after the receive fill reaches 0.
- R6: Bit 6 cannot set while mask bit 6 is 0, even when the 32nd tick arrives.
- R7: A clock with `clr_we_i` high clears each raw bit whose `clr_data_i` bit is 1. A 0 in `clr_data_i` leaves its bit unchanged. A set event in the same clock wins over the clear.
- R8: The error pulses `rx_err_i[3:0]` = {overrun, break, parity, framing} set bits 10, 9, 8 and 7, and `cts_chg_i` sets bit 1. These bits are sticky one clock after the pulse until cleared.
- R9: `masked_o` equals `raw_o & mask_i`, and `irq_o` is the OR of `masked_o`. Both follow `mask_i` in the same clock.
- R10: While reset is held, `raw_o` is all zero. After reset, bit 5 sets at the first clock if the transmit fill is at or below its threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: FIFO mode, 0: single-location mode |
| rx_level_i | input | 5 | Receive FIFO fill, 0 to 16 |
| tx_level_i | input | 5 | Transmit FIFO fill, 0 to 16 |
| rx_push_i | input | 1 | Pulse for each character written into the receive FIFO |
| bit_tick_i | input | 1 | One pulse per serial bit period |
| rx_err_i | input | 4 | Error pulses {overrun, break, parity, framing} |
| cts_chg_i | input | 1 | Pulse when the CTS input changes |
| lvl_we_i | input | 1 | Write strobe for the level select register |
| lvl_wdata_i | input | 6 | [5:3] receive code, [2:0] transmit code |
| mask_i | input | 11 | Interrupt mask, same bit positions as the status |
| clr_we_i | input | 1 | Clear strobe |
| clr_data_i | input | 11 | Write-one-to-clear pattern |
| raw_o | output | 11 | Raw interrupt status |
| masked_o | output | 11 | Masked interrupt status |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong level threshold or a bad edge-detect register in a level trigger shows on bit 4 or 5 of `raw_o` in the clock after the fill crosses the intended boundary. A bad edge-detect register can also make the bit set again after a clear while the condition still holds. An off-by-one in the timeout counter moves bit 6 by one tick, and a missing mask gate lets bit 6 set with its mask off. A lost sticky term makes an error bit fall one clock after its pulse. The bench compares all outputs against its model on every clock, so any of these faults shows within a cycle of the event that exposes it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IRQ_W  = 11;
  localparam int B_CTS  = 1;
  localparam int B_RX   = 4;
  localparam int B_TX   = 5;
  localparam int B_TO   = 6;
  localparam int B_FE   = 7;   // err bits occupy B_FE .. B_FE+3
  localparam int ERR_N  = 4;

  // trigger point in entries; reserved codes fold onto 7/8
  function automatic int level_thresh(input logic [2:0] sel, input int depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      default: return (depth * 7) / 8;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter bit IS_RX = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [2:0]       sel_i,
  input  logic             clr_i,
  output logic             irq_o
);
  import uart_irq_pkg::*;

  logic [LVL_W-1:0] thr;
  logic             hit, hit_q, set;

  assign thr = LVL_W'(level_thresh(sel_i, DEPTH));

  generate
    if (IS_RX) begin : g_rx
      assign hit = fifo_en_i ? (level_i >= thr) : (level_i != '0);
    end else begin : g_tx
      assign hit = fifo_en_i ? (level_i <= thr) : (level_i == '0);
    end
  endgenerate

  assign set = hit & ~hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      hit_q <= hit;
      irq_o <= set | (irq_o & hit & ~clr_i);
    end
  end

  p_level_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hit));
  p_level_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !irq_o);
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TO_BITS = 32,
  parameter int CNT_W   = $clog2(TO_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic push_i,
  input  logic rx_empty_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = tick_i & ~push_i & ~rx_empty_i & (cnt_q == CNT_W'(TO_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (push_i || rx_empty_i)                     cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_W'(TO_BITS))  cnt_q <= cnt_q + 1'b1;
      // mask doubles as enable: no set while masked off
      irq_o <= (expire & mask_i) | (irq_o & ~rx_empty_i & ~clr_i);
    end
  end

  p_to_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(mask_i));
  p_to_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_i |=> !irq_o);
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_sticky_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]);
    p_sticky_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o[i] && !clr_i[i] |=> q_o[i]);
    p_sticky_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !set_i[i] |=> !q_o[i]);
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH   = 16,
  parameter int TO_BITS = 32,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic             rx_push_i,
  input  logic             bit_tick_i,
  input  logic [3:0]       rx_err_i,
  input  logic             cts_chg_i,
  input  logic             lvl_we_i,
  input  logic [5:0]       lvl_wdata_i,
  input  logic [10:0]      mask_i,
  input  logic             clr_we_i,
  input  logic [10:0]      clr_data_i,
  output logic [10:0]      raw_o,
  output logic [10:0]      masked_o,
  output logic             irq_o
);
  import uart_irq_pkg::*;

  localparam logic [2:0] SEL_RST = 3'd2;

  logic [2:0]       rx_sel_q, tx_sel_q;
  logic [IRQ_W-1:0] clr_v;
  logic             rx_irq, tx_irq, to_irq;
  logic [ERR_N:0]   stk_set, stk_clr, stk_q;
  logic             unused_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sel_q <= SEL_RST;
      tx_sel_q <= SEL_RST;
    end else if (lvl_we_i) begin
      rx_sel_q <= lvl_wdata_i[5:3];
      tx_sel_q <= lvl_wdata_i[2:0];
    end
  end

  assign clr_v      = clr_we_i ? clr_data_i : '0;
  assign unused_clr = ^{clr_v[3:2], clr_v[0]};

  uart_irq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IS_RX(1'b1)) u_rx_lvl (
    .clk_i, .rst_ni, .fifo_en_i,
    .level_i(rx_level_i), .sel_i(rx_sel_q), .clr_i(clr_v[B_RX]), .irq_o(rx_irq)
  );

  uart_irq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IS_RX(1'b0)) u_tx_lvl (
    .clk_i, .rst_ni, .fifo_en_i,
    .level_i(tx_level_i), .sel_i(tx_sel_q), .clr_i(clr_v[B_TX]), .irq_o(tx_irq)
  );

  uart_irq_timeout #(.TO_BITS(TO_BITS)) u_to (
    .clk_i, .rst_ni, .tick_i(bit_tick_i), .push_i(rx_push_i),
    .rx_empty_i(rx_level_i == '0), .mask_i(mask_i[B_TO]),
    .clr_i(clr_v[B_TO]), .irq_o(to_irq)
  );

  // sticky slot 0 = cts, slots 1..4 = framing..overrun
  assign stk_set = {rx_err_i, cts_chg_i};
  assign stk_clr = {clr_v[B_FE+ERR_N-1:B_FE], clr_v[B_CTS]};

  uart_irq_sticky #(.W(ERR_N + 1)) u_stk (
    .clk_i, .rst_ni, .set_i(stk_set), .clr_i(stk_clr), .q_o(stk_q)
  );

  assign raw_o    = {stk_q[ERR_N:1], to_irq, tx_irq, rx_irq, 2'b00, stk_q[0], 1'b0};
  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  p_unused_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o[0] == 1'b0 && raw_o[3:2] == 2'b00);
  p_irq_needs_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_i != '0));
endmodule

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic fen = 1;
  logic [4:0] rxl = 0, txl = 0;
  logic push = 0, tick = 0, cts = 0, lwe = 0, cwe = 0;
  logic [3:0] err = 0;
  logic [5:0] lwd = 0;
  logic [10:0] mask = 0, cd = 0;
  logic [10:0] raw, msk;
  logic irq;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  uart_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fen), .rx_level_i(rxl), .tx_level_i(txl),
    .rx_push_i(push), .bit_tick_i(tick), .rx_err_i(err), .cts_chg_i(cts),
    .lvl_we_i(lwe), .lvl_wdata_i(lwd), .mask_i(mask), .clr_we_i(cwe), .clr_data_i(cd),
    .raw_o(raw), .masked_o(msk), .irq_o(irq)
  );

  // behavioural reference model
  logic [10:0] e_raw;
  bit m_rxc, m_txc;
  int m_cnt, m_rsel, m_tsel;

  function automatic int thr_of(input int code);
    int e8;
    case (code) 0: e8 = 1; 1: e8 = 2; 2: e8 = 4; 3: e8 = 6; default: e8 = 7; endcase
    return 16 * e8 / 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_raw = 0; m_rxc = 0; m_txc = 0; m_cnt = 0; m_rsel = 2; m_tsel = 2;
    end else begin
      bit cr, ct, ev, emp;
      logic [10:0] c;
      c  = cwe ? cd : 11'd0;
      cr = fen ? (int'(rxl) >= thr_of(m_rsel)) : (rxl != 0);
      ct = fen ? (int'(txl) <= thr_of(m_tsel)) : (txl == 0);
      emp = (rxl == 0);
      for (int i = 0; i < 4; i++)
        if (err[i]) e_raw[7+i] = 1; else if (c[7+i]) e_raw[7+i] = 0;
      if (cts) e_raw[1] = 1; else if (c[1]) e_raw[1] = 0;
      if (cr && !m_rxc) e_raw[4] = 1; else if (!cr || c[4]) e_raw[4] = 0;
      if (ct && !m_txc) e_raw[5] = 1; else if (!ct || c[5]) e_raw[5] = 0;
      ev = tick && !push && !emp && m_cnt == 31;
      if (ev && mask[6]) e_raw[6] = 1; else if (emp || c[6]) e_raw[6] = 0;
      if (push || emp) m_cnt = 0; else if (tick && m_cnt < 32) m_cnt++;
      if (lwe) begin m_rsel = lwd[5:3]; m_tsel = lwd[2:0]; end
      m_rxc = cr; m_txc = ct;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (raw !== e_raw || msk !== (e_raw & mask) || irq !== |(e_raw & mask)) begin
      errors++;
      $display("FAIL %s cycle %0d: raw=%h masked=%h irq=%b expected raw=%h masked=%h irq=%b",
               cur_req, cycles, raw, msk, irq, e_raw, e_raw & mask, |(e_raw & mask));
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr_lvl(input logic [2:0] r, input logic [2:0] t);
    lwd = {r, t}; lwe = 1; idle(1); lwe = 0;
  endtask

  task automatic wr_clr(input logic [10:0] d);
    cd = d; cwe = 1; idle(1); cwe = 0; cd = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin tick = 1; idle(1); tick = 0; idle(1); end
  endtask

  initial begin
    // R10: reset state
    txl = 5'd16;
    idle(3);
    chk("R10", raw == 11'd0, 1'b1);
    rst_n = 1;
    txl = 0;
    idle(1);
    chk("R10", raw[5], 1'b1);

    // R3: default threshold 8 both ways
    cur_req = "R3";
    mask = 11'h7f2;
    rxl = 7; idle(2);
    chk("R3", raw[4], 1'b0);
    rxl = 8; idle(1);
    chk("R3", raw[4], 1'b1);
    txl = 9; idle(2);
    chk("R3", raw[5], 1'b0);
    txl = 8; idle(1);
    chk("R3", raw[5], 1'b1);

    // R2: clear while condition holds stays clear; drop on false
    cur_req = "R2";
    wr_clr(11'h010);
    idle(2);
    chk("R2", raw[4], 1'b0);
    rxl = 3; idle(1);
    rxl = 10; idle(1);
    chk("R2", raw[4], 1'b1);
    rxl = 2; idle(1);
    chk("R2", raw[4], 1'b0);

    // R1: sweep all codes, fills up then down
    cur_req = "R1";
    for (int code = 0; code < 8; code++) begin
      wr_lvl(code[2:0], code[2:0]);
      rxl = 0; txl = 16; idle(2);
      for (int l = 0; l <= 16; l++) begin rxl = l[4:0]; txl = 5'(16 - l); idle(1); end
      for (int l = 16; l >= 0; l--) begin rxl = l[4:0]; txl = 5'(16 - l); idle(1); end
    end
    wr_lvl(3'd5, 3'd0);
    rxl = 13; txl = 3; idle(2);
    chk("R1", raw[4], 1'b0);
    chk("R1", raw[5], 1'b0);
    rxl = 14; txl = 2; idle(1);
    chk("R1", raw[4], 1'b1);
    chk("R1", raw[5], 1'b1);

    // R4: single location mode
    cur_req = "R4";
    fen = 0; rxl = 0; txl = 1; idle(2);
    chk("R4", raw[4], 1'b0);
    chk("R4", raw[5], 1'b0);
    rxl = 1; txl = 0; idle(1);
    chk("R4", raw[4], 1'b1);
    chk("R4", raw[5], 1'b1);
    fen = 1; wr_lvl(3'd2, 3'd2);

    // R6: timeout blocked while masked off
    cur_req = "R6";
    mask = 11'h7b2;
    rxl = 0; idle(2);
    rxl = 1; push = 1; idle(1); push = 0;
    ticks(40);
    chk("R6", raw[6], 1'b0);

    // R5: timeout on 32nd tick, reset by push, cleared by drain
    cur_req = "R5";
    mask = 11'h7f2;
    push = 1; idle(1); push = 0;
    ticks(20);
    push = 1; idle(1); push = 0;
    ticks(31);
    chk("R5", raw[6], 1'b0);
    tick = 1; idle(1); tick = 0;
    chk("R5", raw[6], 1'b1);
    chk("R9", irq, 1'b1);
    ticks(3);
    rxl = 0; idle(1);
    chk("R5", raw[6], 1'b0);
    rxl = 2; push = 1; idle(1); push = 0;
    ticks(33);
    chk("R5", raw[6], 1'b1);
    cur_req = "R7";
    wr_clr(11'h040);
    chk("R7", raw[6], 1'b0);
    rxl = 0; idle(2);

    // R8: sticky errors and CTS
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin
      err = 4'(1 << i); idle(1); err = 0; idle(3);
      chk("R8", raw[7+i], 1'b1);
    end
    cts = 1; idle(1); cts = 0; idle(2);
    chk("R8", raw[1], 1'b1);

    // R7: zeros no effect, ones clear, set wins
    cur_req = "R7";
    wr_clr(11'h000);
    chk("R7", raw[10], 1'b1);
    wr_clr(11'h182);
    chk("R7", raw[8], 1'b0);
    chk("R7", raw[7], 1'b0);
    chk("R7", raw[1], 1'b0);
    chk("R7", raw[9], 1'b1);
    err = 4'b1000; cd = 11'h400; cwe = 1; idle(1); err = 0; cwe = 0; cd = 0;
    chk("R7", raw[10], 1'b1);

    // R9: mask combinations
    cur_req = "R9";
    for (int k = 0; k < 24; k++) begin
      mask = 11'((k * 11'h2a5) ^ (k << 3));
      err = 4'(k); cts = k[0]; idle(1); err = 0; cts = 0;
      if (k % 5 == 0) wr_clr(11'((k * 37) & 11'h7f2));
      idle(1);
      chk("R9", irq, |(raw & mask));
    end
    mask = 0; idle(1);
    chk("R9", irq, 1'b0);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule